// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which of `NFRAMES` resident frames to evict when a new page must be brought in. Each frame has one referenced flag. A circular pointer, the hand, always rests on the frame that has been resident longest. Every access to a frame raises that frame's flag. When the surrounding memory manager asks for a victim, the block moves the hand round the frames one frame per clock. A frame whose flag is up loses the flag and is passed over, which gives it one more round of residency. The first frame found with its flag down is returned as the victim.

The caller assumes that the new page goes into the returned frame at once. For this reason the block raises that frame's flag and moves the hand one place beyond it, so the newcomer becomes the youngest frame. A request is a level on `req_valid` while the block is idle. `busy` stays high for the whole scan, and the answer is a single-cycle pulse on `resp_valid` carrying `resp_frame`. Accesses can keep arriving during a scan and are not stalled.

Top module: `clock_sc_replacer`

## Requirements
- R1: After a synchronous reset with `rst_n` low, every referenced flag is clear, the hand is at frame 0, and `busy` and `resp_valid` are low. The first victim after reset is therefore frame 0.
- R2: An access (`acc_valid` high on a rising edge) sets the referenced flag of frame number `acc_frame`, a zero-based binary index. The flag stays set until a scan clears it.
- R3: A `req_valid` sampled high while idle starts a scan, and `busy` is high from the next cycle until the edge that decides the victim. A `req_valid` sampled while `busy` is high has no effect and produces no extra response.
- R4: Each scan cycle inspects exactly the frame under the hand. If that frame is referenced, its flag is cleared and the hand moves on by one.
- R5: The first unreferenced frame met is the victim. `resp_valid` is high for exactly one cycle, the cycle after the inspection that found it, and `resp_frame` carries its index.
- R6: The victim's flag is set at the edge that selects it, and the hand moves to victim+1. The next request therefore starts at the frame after the victim.
- R7: If every flag is set, the scan clears all of them in one full revolution and then evicts the frame where it started. That takes NFRAMES+1 inspections, with `resp_valid` high NFRAMES+1 cycles after the accepting edge.
- R8: An access during a scan sets its flag immediately. An access to the frame being inspected in that same cycle makes the frame count as referenced: it is skipped and its flag is cleared.
- R9: The hand advances from NFRAMES-1 to 0. NFRAMES must be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | A frame was accessed this cycle |
| acc_frame | input | $clog2(NFRAMES) | Index of the accessed frame |
| req_valid | input | 1 | Request for a victim frame |
| busy | output | 1 | A scan is in progress |
| resp_valid | output | 1 | One-cycle pulse: victim chosen |
| resp_frame | output | $clog2(NFRAMES) | Index of the chosen victim |

## Verification
The assertions assume that reset is held low for at least one rising edge before release. They also assume that at most one access arrives per cycle, and they allow `req_valid` to stay high across a whole scan. The stimulus changes every input only on falling clock edges, holds reset for several cycles, and keeps `req_valid` asserted through each scan so that the ignored-request rule is exercised. Accesses are injected at chosen scan steps, including one aimed at the frame being inspected at that moment.

// File: rtl/clk_sc_pkg.sv
// Package: types shared by the second-chance victim selector.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package clk_sc_pkg;

    // Scan controller state.
    typedef enum logic [0:0] {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } sc_state_e;

endpackage

// File: rtl/sc_ref_bits.sv
// sc_ref_bits: one referenced flag per frame.
// Sets come from accesses and from victim loading; clears come from the scan.
// Assumes a clear and a load never target the same cycle (scan decides one or the other).
module sc_ref_bits #(
    parameter int NFRAMES = 8,
    localparam int IW = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IW-1:0]      set_idx,
    input  logic               clr_en,
    input  logic [IW-1:0]      clr_idx,
    input  logic               load_en,
    input  logic [IW-1:0]      load_idx,
    output logic [NFRAMES-1:0] bits
);

    genvar gi;
    generate
        for (gi = 0; gi < NFRAMES; gi++) begin : g_flag
            logic hit_set;
            logic hit_clr;
            // Decode which requests address this frame.
            always_comb begin
                hit_set = (set_en && set_idx == IW'(gi)) || (load_en && load_idx == IW'(gi));
                hit_clr = clr_en && clr_idx == IW'(gi);
            end
            // Flag register: clear from the scan wins over a same-cycle access.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bits[gi] <= 1'b0;
                else if (hit_clr)
                    bits[gi] <= 1'b0;
                else if (hit_set)
                    bits[gi] <= 1'b1;
            end
        end
    endgenerate

    // An access not overridden by a clear leaves its flag set.
    assert_access_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_idx == set_idx)) |=> bits[$past(set_idx)]);

    // A scan clear drops the flag.
    assert_scan_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !bits[$past(clr_idx)]);

    // Without a scan clear, no flag ever falls.
    assert_no_stray_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (($past(bits) & ~bits) == '0));

endmodule

// File: rtl/sc_hand.sv
// sc_hand: the circular pointer to the oldest frame.
// Assumes NFRAMES is a power of two so that natural overflow wraps.
module sc_hand #(
    parameter int NFRAMES = 8,
    localparam int IW = $clog2(NFRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] hand
);

    // Pointer register: step by one on each inspected frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hand <= '0;
        else if (advance)
            hand <= hand + 1'b1;
    end

    // Step from the last frame goes back to frame 0.
    assert_hand_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hand == IW'(NFRAMES - 1)) |=> (hand == '0));

    // The hand moves only when told to.
    assert_hand_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(hand));

endmodule

// File: rtl/sc_scan_fsm.sv
// sc_scan_fsm: accepts a victim request, walks one frame per cycle,
// and reports the first unreferenced frame as a one-cycle response.
// Assumes hand_ref already merges the stored flag with a same-cycle access.
module sc_scan_fsm
    import clk_sc_pkg::*;
#(
    parameter int NFRAMES = 8,
    localparam int IW = $clog2(NFRAMES),
    localparam int CW = $clog2(NFRAMES + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [IW-1:0] hand,
    input  logic          hand_ref,
    output logic          busy,
    output logic          inspect,
    output logic          clr_en,
    output logic          load_en,
    output logic          resp_valid,
    output logic [IW-1:0] resp_frame
);

    sc_state_e state;
    logic [CW-1:0] steps;

    // Decode per-cycle actions from the state and the flag under the hand.
    always_comb begin
        busy    = (state == SC_SCAN);
        inspect = busy;
        clr_en  = inspect && hand_ref;
        load_en = inspect && !hand_ref;
    end

    // State register: idle until a request, scan until a victim is found.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SC_IDLE;
        else if (state == SC_IDLE && req_valid)
            state <= SC_SCAN;
        else if (load_en)
            state <= SC_IDLE;
    end

    // Step counter for the scan-length bound.
    always_ff @(posedge clk) begin
        if (!rst_n)
            steps <= '0;
        else if (state == SC_IDLE)
            steps <= '0;
        else
            steps <= steps + 1'b1;
    end

    // Response registers: pulse with the victim index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_frame <= '0;
        end else begin
            resp_valid <= load_en;
            if (load_en)
                resp_frame <= hand;
        end
    end

    // A scan only starts after a request.
    assert_scan_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // The response is a single-cycle pulse, and the block is idle while it shows.
    assert_resp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    assert_resp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy);

    // No scan takes more than NFRAMES+1 inspections.
    assert_scan_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (steps <= CW'(NFRAMES)));

endmodule

// File: rtl/clock_sc_replacer.sv
// clock_sc_replacer: second-chance victim selector over NFRAMES frames.
// Assumes NFRAMES is a power of two and at most one access per cycle.
module clock_sc_replacer #(
    parameter int NFRAMES = 8,
    localparam int FW = $clog2(NFRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [FW-1:0] acc_frame,
    input  logic          req_valid,
    output logic          busy,
    output logic          resp_valid,
    output logic [FW-1:0] resp_frame
);

    logic [NFRAMES-1:0] ref_bits;
    logic [FW-1:0]      hand;
    logic               hand_ref;
    logic               inspect;
    logic               clr_en;
    logic               load_en;

    // Flag under the hand, including an access landing on it this cycle.
    always_comb begin
        hand_ref = ref_bits[hand] || (acc_valid && acc_frame == hand);
    end

    sc_ref_bits #(.NFRAMES(NFRAMES)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (acc_valid),
        .set_idx  (acc_frame),
        .clr_en   (clr_en),
        .clr_idx  (hand),
        .load_en  (load_en),
        .load_idx (hand),
        .bits     (ref_bits)
    );

    sc_hand #(.NFRAMES(NFRAMES)) u_hand (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (inspect),
        .hand    (hand)
    );

    sc_scan_fsm #(.NFRAMES(NFRAMES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hand       (hand),
        .hand_ref   (hand_ref),
        .busy       (busy),
        .inspect    (inspect),
        .clr_en     (clr_en),
        .load_en    (load_en),
        .resp_valid (resp_valid),
        .resp_frame (resp_frame)
    );

    // The returned victim carries a set flag and the hand sits just past it.
    assert_victim_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (ref_bits[resp_frame] && hand == FW'(resp_frame + 1'b1)));

    // A same-cycle access to the inspected frame prevents its eviction.
    assert_same_cycle_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inspect && acc_valid && acc_frame == hand) |=> !resp_valid);

endmodule

// File: tb/clock_sc_replacer_test.sv
// Scoreboard bench: the driver models the expected victim and its cycle,
// and the monitor compares each response against the queue.
module clock_sc_replacer_test;

    localparam int N  = 8;
    localparam int FW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [FW-1:0] acc_frame = '0;
    logic          req_valid = 1'b0;
    logic          busy;
    logic          resp_valid;
    logic [FW-1:0] resp_frame;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    logic [N-1:0]  mbits = '0;
    logic [FW-1:0] mhand = '0;

    logic [FW-1:0] exp_frame[$];
    int            exp_cyc[$];
    string         exp_tag[$];

    clock_sc_replacer #(.NFRAMES(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_frame  (acc_frame),
        .req_valid  (req_valid),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_frame (resp_frame)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic touch(input logic [FW-1:0] f);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_frame = f;
        mbits[f]  = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Driver: hold the request through the scan and model each inspection.
    task automatic victim_req(input string tag, input bit use_acc,
                              input int acc_step, input logic [FW-1:0] af);
        bit hit;
        bit acc_now;
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        for (int s = 0; s <= N; s++) begin
            @(negedge clk);
            if (s == 0) check({tag, " R3 busy"}, int'(busy), 1);
            acc_now   = use_acc && (s == acc_step);
            acc_valid = acc_now;
            acc_frame = af;
            hit = mbits[mhand] || (acc_now && af == mhand);
            if (acc_now) mbits[af] = 1'b1;
            if (hit) begin
                mbits[mhand] = 1'b0;
                mhand = mhand + 1'b1;
                @(posedge clk);
            end else begin
                mbits[mhand] = 1'b1;
                exp_frame.push_back(mhand);
                exp_cyc.push_back(cyc + 1);
                exp_tag.push_back(tag);
                mhand = mhand + 1'b1;
                @(posedge clk);
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        acc_valid = 1'b0;
    endtask

    // Monitor: compare each response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_frame.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R3: actual unexpected response frame %0d expected none", resp_frame);
            end else begin
                string t;
                int ef;
                int ec;
                t  = exp_tag.pop_front();
                ef = int'(exp_frame.pop_front());
                ec = exp_cyc.pop_front();
                check({t, " R5 frame"}, int'(resp_frame), ef);
                check({t, " R5 cycle"}, cyc, ec);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 resp after reset", int'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy idle", int'(busy), 0);

        victim_req("R1", 0, 0, '0);            // victim 0
        victim_req("R6", 0, 0, '0);            // victim 1
        touch(3'd2);
        touch(3'd3);
        victim_req("R2 R4", 0, 0, '0);         // skips 2,3 -> victim 4
        for (int f = 0; f < N; f++) touch(FW'(f));
        victim_req("R7", 0, 0, '0);            // full revolution -> victim 5
        victim_req("R8", 1, 0, 3'd6);          // 6 hit same cycle -> victim 7
        victim_req("R8 R9", 1, 0, 3'd1);       // hand wrapped -> victim 0
        victim_req("R8", 0, 0, '0);            // 1 was set mid-scan -> victim 2

        repeat (6) @(negedge clk);
        check("R3 idle at end", int'(busy), 0);
        check("R5 all responses seen", exp_frame.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule